// File: doc/BRIEF.md
# Frequency Display Digit Port Controller

This block sits on a processor's I/O bus and drives a multi-digit front-panel frequency readout. The processor writes three independent output ports. The digit-select port chooses which display position is enabled. The numeral port gives the BCD code that the enabled position shows. The decimal-point port gives a one-of-four position code, which the block turns into active-low decimal point drives.

A port is written when the output strobe is high and the port address matches that port's number. On the next rising clock edge the port register takes the bus data, and it keeps that value until the next write to it. The digit-select logic is a two-state machine. `ST_BLANK` is entered on reset and enables no digit. Transition `T_FIRST_SEL` (a digit-port write in `ST_BLANK`) moves it to `ST_LIT`. In `ST_LIT`, transition `T_RESEL` (a further digit-port write) reloads the selected position and stays in `ST_LIT`. Transition `T_RESET` (reset asserted) returns it from either state to `ST_BLANK`. The seven-segment decoding inside the display and the analog buffers are outside this block.

Top module: `fdd_display_ctrl`

## Requirements
- R1: A port is written only when `out_stb` is 1 and `port_addr` equals its number: 9 for digit select, 2 for the numeral, 5 for the decimal point. A strobed write to any other address changes no output.
- R2: After a digit-port write of value d in bus bits 2..0, from the next cycle onward `digit_en_n` is all ones except bit d, which is 0. The value holds until the next digit-port write.
- R3: After a numeral-port write, from the next cycle `bcd_out` equals bus bits 3..0. Codes 10 to 15 are passed through unchanged.
- R4: After a decimal-point-port write whose bits 3..0 contain exactly one 1, from the next cycle `dp_n` is the bitwise inverse of those bits.
- R5: After a decimal-point-port write whose bits 3..0 are not exactly one-hot (zero bits set, or two or more), `dp_n` is 4'hF.
- R6: While `rst_n` is low, the block enables no digit (`digit_en_n` all ones), `bcd_out` is 0 and `dp_n` is 4'hF. Reset takes priority over a write strobe in the same cycle.
- R7: When `out_stb` is 0, no port changes, whatever the values of `port_addr` and the bus.
- R8: A write ignores bus bits above the field it uses: bits 7..3 for digit select, and bits 7..4 for the numeral and decimal-point ports.
- R9: A write to one port leaves the outputs of the other two ports unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| out_stb | input | 1 | Processor output strobe, active high |
| port_addr | input | 4 | Decoded output port number |
| bus_data | input | 8 | I/O bus data |
| digit_en_n | output | 8 | Active-low one-hot digit enable |
| bcd_out | output | 4 | BCD numeral lines (bit 3 = D, bit 0 = A) |
| dp_n | output | 4 | Active-low decimal point drives |

## Verification
Two events can arrive in the same cycle: a reset and a strobed digit-port write. The bench holds `rst_n` low while it presents a valid digit-port write. It then checks that no digit is enabled, which shows that reset wins. In the same way, a write to one port can land in the cycle after a write to another port, so every sweep step also checks the two ports it did not write. Those ports must keep their values.

// File: rtl/fdd_pkg.sv
package fdd_pkg;
    typedef enum logic [0:0] {
        ST_BLANK = 1'b0,
        ST_LIT   = 1'b1
    } disp_state_t;

    function automatic int unsigned count_ones(input logic [31:0] v, input int unsigned w);
        int unsigned n;
        n = 0;
        for (int unsigned i = 0; i < 32; i++) begin
            if (i < w && v[i]) n++;
        end
        return n;
    endfunction
endpackage

// File: rtl/fdd_port_reg.sv
module fdd_port_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (ld) q <= d;
    end
endmodule

// File: rtl/fdd_digit_fsm.sv
module fdd_digit_fsm
    import fdd_pkg::*;
#(
    parameter int SEL_W = 3,
    localparam int NDIG = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sel,
    input  logic [SEL_W-1:0] sel_in,
    output logic [NDIG-1:0]  en_n
);
    disp_state_t      state_q, state_d;
    logic [SEL_W-1:0] sel_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BLANK: if (wr_sel) state_d = ST_LIT;   // T_FIRST_SEL
            ST_LIT:   state_d = ST_LIT;               // T_RESEL stays here
            default:  state_d = ST_BLANK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BLANK;                      // T_RESET
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            if (wr_sel) sel_q <= sel_in;
        end
    end

    always_comb begin
        en_n = '1;
        unique case (state_q)
            ST_BLANK: en_n = '1;
            ST_LIT: begin
                for (int i = 0; i < NDIG; i++) begin
                    if (sel_q == SEL_W'(i)) en_n[i] = 1'b0;
                end
            end
            default: en_n = '1;
        endcase
    end
endmodule

// File: rtl/fdd_dp_drive.sv
module fdd_dp_drive
    import fdd_pkg::*;
#(
    parameter int DP_W = 4
) (
    input  logic [DP_W-1:0] code,
    output logic [DP_W-1:0] dp_n
);
    logic valid;

    always_comb valid = (count_ones(32'(code), DP_W) == 1);

    for (genvar g = 0; g < DP_W; g++) begin : g_dp
        assign dp_n[g] = valid ? ~code[g] : 1'b1;
    end
endmodule

// File: rtl/fdd_display_ctrl.sv
module fdd_display_ctrl #(
    parameter int BUS_W    = 8,
    parameter int ADDR_W   = 4,
    parameter int SEL_W    = 3,
    parameter int BCD_W    = 4,
    parameter int DP_W     = 4,
    parameter int PORT_DIG = 9,
    parameter int PORT_VAL = 2,
    parameter int PORT_DP  = 5,
    localparam int NDIG    = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              out_stb,
    input  logic [ADDR_W-1:0] port_addr,
    input  logic [BUS_W-1:0]  bus_data,
    output logic [NDIG-1:0]   digit_en_n,
    output logic [BCD_W-1:0]  bcd_out,
    output logic [DP_W-1:0]   dp_n
);
    logic wr_dig, wr_val, wr_dp;
    logic [DP_W-1:0] dp_code;

    always_comb begin
        wr_dig = out_stb && (port_addr == ADDR_W'(PORT_DIG));
        wr_val = out_stb && (port_addr == ADDR_W'(PORT_VAL));
        wr_dp  = out_stb && (port_addr == ADDR_W'(PORT_DP));
    end

    fdd_digit_fsm #(.SEL_W(SEL_W)) u_dig (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (wr_dig),
        .sel_in (bus_data[SEL_W-1:0]),
        .en_n   (digit_en_n)
    );

    fdd_port_reg #(.W(BCD_W)) u_val (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (wr_val),
        .d     (bus_data[BCD_W-1:0]),
        .q     (bcd_out)
    );

    fdd_port_reg #(.W(DP_W)) u_dpreg (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (wr_dp),
        .d     (bus_data[DP_W-1:0]),
        .q     (dp_code)
    );

    fdd_dp_drive #(.DP_W(DP_W)) u_dpdrv (
        .code (dp_code),
        .dp_n (dp_n)
    );
endmodule

// File: rtl/fdd_display_chk.sv
module fdd_display_chk #(
    parameter int BUS_W    = 8,
    parameter int ADDR_W   = 4,
    parameter int SEL_W    = 3,
    parameter int BCD_W    = 4,
    parameter int DP_W     = 4,
    parameter int PORT_DIG = 9,
    parameter int PORT_VAL = 2,
    parameter int PORT_DP  = 5,
    localparam int NDIG    = 1 << SEL_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_stb,
    input logic [ADDR_W-1:0] port_addr,
    input logic [BUS_W-1:0]  bus_data,
    input logic [NDIG-1:0]   digit_en_n,
    input logic [BCD_W-1:0]  bcd_out,
    input logic [DP_W-1:0]   dp_n
);
    logic a_dig, a_val, a_dp;
    assign a_dig = out_stb && (port_addr == ADDR_W'(PORT_DIG));
    assign a_val = out_stb && (port_addr == ADDR_W'(PORT_VAL));
    assign a_dp  = out_stb && (port_addr == ADDR_W'(PORT_DP));

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (digit_en_n == '1 && bcd_out == '0 && dp_n == '1)); // R6
    AST_DIGIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~digit_en_n)); // R2
    AST_DIGIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n) a_dig |=> (digit_en_n[$past(bus_data[SEL_W-1:0])] == 1'b0)); // R2
    AST_DIGIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !a_dig |=> $stable(digit_en_n)); // R7
    AST_BCD_LOAD: assert property (@(posedge clk) disable iff (!rst_n) a_val |=> (bcd_out == $past(bus_data[BCD_W-1:0]))); // R3
    AST_BCD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !a_val |=> $stable(bcd_out)); // R9
    AST_DP_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (a_dp && $onehot(bus_data[DP_W-1:0])) |=> (dp_n == ~$past(bus_data[DP_W-1:0]))); // R4
    AST_DP_BAD: assert property (@(posedge clk) disable iff (!rst_n) (a_dp && !$onehot(bus_data[DP_W-1:0])) |=> (dp_n == '1)); // R5
    AST_DP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) $countones(~dp_n) <= 1); // R5
    AST_DP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !a_dp |=> $stable(dp_n)); // R1
endmodule

bind fdd_display_ctrl fdd_display_chk #(
    .BUS_W(BUS_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W), .BCD_W(BCD_W), .DP_W(DP_W),
    .PORT_DIG(PORT_DIG), .PORT_VAL(PORT_VAL), .PORT_DP(PORT_DP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_stb    (out_stb),
    .port_addr  (port_addr),
    .bus_data   (bus_data),
    .digit_en_n (digit_en_n),
    .bcd_out    (bcd_out),
    .dp_n       (dp_n)
);

// File: tb/sim_fdd_display_ctrl.sv
`timescale 1ns/1ps
module sim_fdd_display_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       out_stb = 1'b0;
    logic [3:0] port_addr = '0;
    logic [7:0] bus_data = '0;
    logic [7:0] digit_en_n;
    logic [3:0] bcd_out;
    logic [3:0] dp_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] exp_en  = 8'hFF;
    logic [3:0] exp_bcd = 4'h0;
    logic [3:0] exp_dp  = 4'hF;

    always #2.5 clk = ~clk;

    fdd_display_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .out_stb(out_stb), .port_addr(port_addr),
        .bus_data(bus_data), .digit_en_n(digit_en_n), .bcd_out(bcd_out), .dp_n(dp_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk({req, " digit_en_n"}, 32'(digit_en_n), 32'(exp_en));
        chk({req, " bcd_out"},    32'(bcd_out),    32'(exp_bcd));
        chk({req, " dp_n"},       32'(dp_n),       32'(exp_dp));
    endtask

    task automatic wr(input logic stb, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        out_stb = stb; port_addr = a; bus_data = d;
        @(negedge clk);
        out_stb = 1'b0; bus_data = 8'h00; port_addr = 4'h0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R6: reset held while a valid digit write is presented
        out_stb = 1'b1; port_addr = 4'd9; bus_data = 8'h03;
        repeat (3) @(negedge clk);
        chk_all("R6 reset beats write");
        out_stb = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R6 after release");

        // R2, R8, R9: digit sweep with upper bus bits set
        for (int d = 0; d < 8; d++) begin
            wr(1'b1, 4'd9, 8'hF8 | 8'(d));
            exp_en = ~(8'h01 << d);
            chk_all("R2 R8 R9 digit");
        end

        // R3, R8, R9: numeral sweep incl. codes above 9
        for (int v = 0; v < 16; v++) begin
            wr(1'b1, 4'd2, 8'hA0 | 8'(v));
            exp_bcd = 4'(v);
            chk_all("R3 R8 R9 bcd");
        end

        // R4, R5, R8: decimal point sweep
        for (int c = 0; c < 16; c++) begin
            int n;
            n = 0;
            for (int b = 0; b < 4; b++) n += (c >> b) & 1;
            wr(1'b1, 4'd5, 8'h50 | 8'(c));
            exp_dp = (n == 1) ? ~4'(c) : 4'hF;
            chk_all(n == 1 ? "R4 dp one-hot" : "R5 dp invalid");
        end
        wr(1'b1, 4'd5, 8'h04);
        exp_dp = 4'hB;
        chk_all("R4 dp set");

        // R1: strobed writes to other addresses change nothing
        for (int a = 0; a < 16; a++) begin
            if (a != 2 && a != 5 && a != 9) begin
                wr(1'b1, 4'(a), 8'h01);
                chk_all("R1 foreign address");
            end
        end

        // R7: no strobe on the three real ports
        wr(1'b0, 4'd9, 8'h02);
        chk_all("R7 no strobe digit");
        wr(1'b0, 4'd2, 8'h05);
        chk_all("R7 no strobe bcd");
        wr(1'b0, 4'd5, 8'h01);
        chk_all("R7 no strobe dp");

        // R6: reset from lit state
        @(negedge clk);
        rst_n = 1'b0;
        exp_en = 8'hFF; exp_bcd = 4'h0; exp_dp = 4'hF;
        @(negedge clk);
        chk_all("R6 reset from lit");
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule